// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two bidirectional data ports, A and B, and carries data from one to the other in either direction. Each direction has its own capture register. The A-to-B register samples the A port on the rising edge of its own capture clock. The B-to-A register samples the B port on the rising edge of a second capture clock. The port that is driving can output one of two things: the live input of the opposite port, passed straight through combinationally, or the value held in that direction's register. A per-direction select makes that choice.

An active-low enable and a direction input decide which port drives, if either does. With the enable high, both ports are isolated. The registers still capture in that state, so data can be staged in either direction before either port is enabled.

Tri-state pins are split into separate input, output and output-enable vectors for each port, so the design stays synthesizable. The enable vectors are meant for the pad ring. The data path is plain combinational logic with registers, with no valid/ready handshake: a bus transceiver has no back-pressure. Every bus cycle is accepted at once, and each capture edge overwrites the register.

Top module: `xcvr_reg_bus`

## Requirements
- R1: While `rst_n` is low, both capture registers are cleared to zero asynchronously. With a select at 1 (stored), the corresponding output then reads zero.
- R2: A rising edge on `cap_ab_clk` loads `a_in` into the A-to-B register. A rising edge on `cap_ba_clk` loads `b_in` into the B-to-A register.
- R3: With `oe_n` high (isolation), `a_oe` and `b_oe` are both all zeros, whatever the value of `dir_a2b`.
- R4: With `oe_n` low and `dir_a2b` high, `b_oe` is all ones and `a_oe` is all zeros. With `oe_n` low and `dir_a2b` low, `a_oe` is all ones and `b_oe` is all zeros.
- R5: With `sel_ab` at 0 (transparent), `b_out` equals `a_in` in the same cycle. With `sel_ab` at 1 (stored), `b_out` equals the A-to-B register and does not follow later changes on `a_in`.
- R6: With `sel_ba` at 0, `a_out` equals `b_in` in the same cycle. With `sel_ba` at 1, `a_out` equals the B-to-A register.
- R7: Capture on either register works while the ports are isolated (`oe_n` high).
- R8: A capture edge on one direction's clock leaves the other direction's register unchanged. Both registers can capture while one port is driving.
- R9: `a_oe` and `b_oe` are never nonzero at the same time. Each of them is either all ones or all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| cap_ab_clk | input | 1 | Rising edge captures A into the A-to-B register |
| cap_ba_clk | input | 1 | Rising edge captures B into the B-to-A register |
| oe_n | input | 1 | Active-low output enable; high isolates both ports |
| dir_a2b | input | 1 | 1: B port drives; 0: A port drives |
| sel_ab | input | 1 | Source for B output: 0 live A input, 1 stored value |
| sel_ba | input | 1 | Source for A output: 0 live B input, 1 stored value |
| a_in | input | WIDTH | Value sensed on the A pins |
| a_out | output | WIDTH | Value for the A pins |
| a_oe | output | WIDTH | Per-bit drive enable for the A pins |
| b_in | input | WIDTH | Value sensed on the B pins |
| b_out | output | WIDTH | Value for the B pins |
| b_oe | output | WIDTH | Per-bit drive enable for the B pins |

## Verification
The bench builds the block with WIDTH set to 4. At that width it can sweep every pair of A and B input values through both transparent paths. It also captures and reads back every value in stored mode, in both directions, under isolation and under each drive direction. All four combinations of enable and direction are checked against the expected enable vectors. Capture on one clock is checked against the other register's stored output, so crossed paths between the two registers are exposed.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    DRIVE_NONE = 2'd0,
    DRIVE_A    = 2'd1,
    DRIVE_B    = 2'd2
  } drive_e;

  localparam int unsigned NUM_DIRS = 2;
  localparam int unsigned IDX_AB   = 0;
  localparam int unsigned IDX_BA   = 1;

  function automatic drive_e decode_drive(input logic oe_n, input logic dir_a2b);
    if (oe_n)         return DRIVE_NONE;
    else if (dir_a2b) return DRIVE_B;
    else              return DRIVE_A;
  endfunction

endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             cap_clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge cap_clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             use_stored,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] y
);

  always_comb begin
    if (use_stored) y = stored;
    else            y = live;
  end

endmodule

// File: rtl/xcvr_drive_decode.sv
module xcvr_drive_decode
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             oe_n,
  input  logic             dir_a2b,
  output logic [WIDTH-1:0] a_oe,
  output logic [WIDTH-1:0] b_oe
);

  drive_e mode;

  always_comb begin
    mode = decode_drive(oe_n, dir_a2b);
    a_oe = {WIDTH{mode == DRIVE_A}};
    b_oe = {WIDTH{mode == DRIVE_B}};
  end

endmodule

// File: rtl/xcvr_reg_bus.sv
module xcvr_reg_bus
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             rst_n,
  input  logic             cap_ab_clk,
  input  logic             cap_ba_clk,
  input  logic             oe_n,
  input  logic             dir_a2b,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_oe
);

  logic [NUM_DIRS-1:0] dir_clk;
  logic [NUM_DIRS-1:0] dir_sel;
  logic [WIDTH-1:0]    dir_src    [NUM_DIRS];
  logic [WIDTH-1:0]    dir_stored [NUM_DIRS];
  logic [WIDTH-1:0]    dir_y      [NUM_DIRS];

  // Index 0 carries A towards B, index 1 carries B towards A.
  assign dir_clk[IDX_AB] = cap_ab_clk;
  assign dir_clk[IDX_BA] = cap_ba_clk;
  assign dir_sel[IDX_AB] = sel_ab;
  assign dir_sel[IDX_BA] = sel_ba;
  assign dir_src[IDX_AB] = a_in;
  assign dir_src[IDX_BA] = b_in;

  for (genvar g = 0; g < NUM_DIRS; g++) begin : g_path
    xcvr_capture_reg #(.WIDTH(WIDTH)) u_reg (
      .cap_clk (dir_clk[g]),
      .rst_n   (rst_n),
      .d       (dir_src[g]),
      .q       (dir_stored[g])
    );

    xcvr_path_mux #(.WIDTH(WIDTH)) u_mux (
      .use_stored (dir_sel[g]),
      .live       (dir_src[g]),
      .stored     (dir_stored[g]),
      .y          (dir_y[g])
    );
  end

  assign b_out = dir_y[IDX_AB];
  assign a_out = dir_y[IDX_BA];

  xcvr_drive_decode #(.WIDTH(WIDTH)) u_decode (
    .oe_n    (oe_n),
    .dir_a2b (dir_a2b),
    .a_oe    (a_oe),
    .b_oe    (b_oe)
  );

endmodule

// File: rtl/xcvr_reg_bus_checker.sv
module xcvr_reg_bus_checker #(
  parameter int unsigned WIDTH = 8
) (
  input logic             rst_n,
  input logic             cap_ab_clk,
  input logic             cap_ba_clk,
  input logic             oe_n,
  input logic             dir_a2b,
  input logic             sel_ab,
  input logic             sel_ba,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic [WIDTH-1:0] a_oe,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_out,
  input logic [WIDTH-1:0] b_oe
);

  logic [WIDTH-1:0] shadow_ab;
  logic [WIDTH-1:0] shadow_ba;

  always_ff @(posedge cap_ab_clk or negedge rst_n) begin
    if (!rst_n) shadow_ab <= '0;
    else        shadow_ab <= a_in;
  end

  always_ff @(posedge cap_ba_clk or negedge rst_n) begin
    if (!rst_n) shadow_ba <= '0;
    else        shadow_ba <= b_in;
  end

  assert_oe_exclusive_R9: assert property (@(posedge cap_ab_clk) disable iff (!rst_n)
    !((|a_oe) && (|b_oe)));

  assert_oe_uniform_R9: assert property (@(posedge cap_ba_clk) disable iff (!rst_n)
    ((a_oe == '0) || (&a_oe)) && ((b_oe == '0) || (&b_oe)));

  assert_isolated_R3: assert property (@(posedge cap_ab_clk) disable iff (!rst_n)
    oe_n |-> (a_oe == '0 && b_oe == '0));

  assert_drive_dir_R4: assert property (@(posedge cap_ba_clk) disable iff (!rst_n)
    !oe_n |-> (dir_a2b ? (&b_oe && a_oe == '0) : (&a_oe && b_oe == '0)));

  assert_live_ab_R5: assert property (@(posedge cap_ab_clk) disable iff (!rst_n)
    !sel_ab |-> b_out == a_in);

  assert_held_ab_R5: assert property (@(negedge cap_ab_clk) disable iff (!rst_n)
    sel_ab |-> b_out == shadow_ab);

  assert_live_ba_R6: assert property (@(posedge cap_ba_clk) disable iff (!rst_n)
    !sel_ba |-> a_out == b_in);

  assert_held_ba_R6: assert property (@(negedge cap_ba_clk) disable iff (!rst_n)
    sel_ba |-> a_out == shadow_ba);

endmodule

bind xcvr_reg_bus xcvr_reg_bus_checker #(.WIDTH(WIDTH)) u_checker (.*);

// File: tb/tb_xcvr_reg_bus.sv
module tb_xcvr_reg_bus;

  localparam int W = 4;
  localparam int NV = 1 << W;
  localparam logic [W-1:0] ONES = '1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         cap_ab_clk = 1'b0;
  logic         cap_ba_clk = 1'b0;
  logic         oe_n = 1'b1;
  logic         dir_a2b = 1'b0;
  logic         sel_ab = 1'b0;
  logic         sel_ba = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  int checks = 0;
  int failures = 0;

  xcvr_reg_bus #(.WIDTH(W)) dut (
    .rst_n(rst_n), .cap_ab_clk(cap_ab_clk), .cap_ba_clk(cap_ba_clk),
    .oe_n(oe_n), .dir_a2b(dir_a2b), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_ab();
    @(negedge clk); cap_ab_clk = 1'b1;
    @(posedge clk); #2 cap_ab_clk = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_ba();
    @(negedge clk); cap_ba_clk = 1'b1;
    @(posedge clk); #2 cap_ba_clk = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_both();
    @(negedge clk); cap_ab_clk = 1'b1; cap_ba_clk = 1'b1;
    @(posedge clk); #2 cap_ab_clk = 1'b0; cap_ba_clk = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset clears both registers, seen through stored mode
    a_in = 4'h9; b_in = 4'h6; sel_ab = 1'b1; sel_ba = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 b_out in reset", b_out, '0);
    chk("R1 a_out in reset", a_out, '0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 b_out after reset", b_out, '0);
    chk("R1 a_out after reset", a_out, '0);

    // R3, R4, R9: every enable/direction pair
    for (int k = 0; k < 4; k++) begin
      oe_n = k[1]; dir_a2b = k[0];
      #1;
      if (oe_n) begin
        chk("R3 a_oe isolated", a_oe, '0);
        chk("R3 b_oe isolated", b_oe, '0);
      end else begin
        chk("R4 a_oe", a_oe, dir_a2b ? '0 : ONES);
        chk("R4 b_oe", b_oe, dir_a2b ? ONES : '0);
      end
      chk("R9 exclusive", {{(W-1){1'b0}}, (|a_oe) & (|b_oe)}, '0);
      @(negedge clk);
    end

    // R5, R6: transparent paths, all input pairs
    sel_ab = 1'b0; sel_ba = 1'b0;
    for (int va = 0; va < NV; va++) begin
      for (int vb = 0; vb < NV; vb++) begin
        a_in = va[W-1:0]; b_in = vb[W-1:0];
        #1;
        chk("R5 live a->b", b_out, va[W-1:0]);
        chk("R6 live b->a", a_out, vb[W-1:0]);
      end
    end

    // R2, R5, R7: stored A->B under isolation, every value; R8 other side untouched
    oe_n = 1'b1; sel_ab = 1'b1; sel_ba = 1'b1;
    for (int v = 0; v < NV; v++) begin
      a_in = v[W-1:0]; b_in = ~v[W-1:0];
      pulse_ab();
      a_in = ~v[W-1:0];
      #1;
      chk("R2 R7 stored a->b isolated", b_out, v[W-1:0]);
      chk("R8 b->a untouched", a_out, '0);
    end

    // R2, R6, R7: stored B->A under isolation; R8 A->B keeps last value
    for (int v = 0; v < NV; v++) begin
      b_in = v[W-1:0]; a_in = v[W-1:0] ^ 4'h5;
      pulse_ba();
      b_in = ~v[W-1:0];
      #1;
      chk("R2 R7 stored b->a isolated", a_out, v[W-1:0]);
      chk("R8 a->b untouched", b_out, ONES);
    end

    // R8: both capture while each port drives
    oe_n = 1'b0;
    for (int d = 0; d < 2; d++) begin
      dir_a2b = d[0];
      for (int v = 0; v < NV; v++) begin
        a_in = v[W-1:0]; b_in = v[W-1:0] ^ 4'hA;
        pulse_both();
        a_in = 4'h0; b_in = 4'h0;
        #1;
        chk("R8 a->b while driving", b_out, v[W-1:0]);
        chk("R8 b->a while driving", a_out, v[W-1:0] ^ 4'hA);
        chk("R4 drive held", dir_a2b ? b_oe : a_oe, ONES);
      end
    end

    // R1: asynchronous clear mid-run
    @(negedge clk); #3 rst_n = 1'b0; #1;
    chk("R1 async clear a->b", b_out, '0);
    chk("R1 async clear b->a", a_out, '0);
    @(negedge clk); rst_n = 1'b1;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule